// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides, once per issue slot, which resident warp of a streaming multiprocessor sends its next instruction to the processing lanes. Each resident warp presents a valid flag and the three register numbers of its next instruction: two sources and one destination. The scheduler keeps a pending-write bit for every register of every warp. A warp is eligible only when none of the registers its instruction names has a write still outstanding. A warp stalled on a slow load therefore drops out of contention, and the other warps keep issuing.

Among the eligible warps, the grant rotates. The search begins at the warp just after the last one granted. A granted instruction holds the lanes for a fixed number of cycles, so grants come no closer together than that. Each grant marks the instruction's destination register as pending. A writeback completion, tagged with a warp and a register, clears that mark. The block also holds a small combinational helper. It turns a thread's three-dimensional coordinates within its block into the warp that thread belongs to and the thread's lane within that warp.

Top module: `warp_sched_top`

## Requirements
- R1: An active-low asynchronous reset forces `issue_valid` low, clears every pending bit and sets the rotation start to warp 0. After `rst_n` rises, the first grant can appear on the third rising edge.
- R2: A warp is granted only if its `warp_valid` bit is 1 and none of its source A, source B or destination registers is pending.
- R3: A grant marks the granted instruction's destination register as pending for that warp. A warp whose unchanged instruction names that register then stays blocked.
- R4: A writeback (`wb_valid`=1 with `wb_warp`, `wb_reg`) clears that pending bit at the clock edge where it is sampled. The warp can be granted from the following edge onward.
- R5: When a grant marks, and a writeback clears, the same warp and register on the same edge, the bit ends up pending.
- R6: A grant goes to the first eligible warp at or after the warp following the last granted one, counting upward and wrapping from NUM_WARPS-1 to 0.
- R7: In an open slot with no eligible warp, `issue_valid` stays low and the rotation start does not move.
- R8: Grants are at least ISSUE_CYCLES (default 4) clock edges apart. A grant happens on the first edge where the slot is free and some warp is eligible.
- R9: `issue_valid` is a registered one-cycle pulse per grant, and `issue_warp` carries the granted warp as a binary index in that same cycle.
- R10: `thr_warp` = L / 32 and `thr_lane` = L mod 32, where L = `thr_x` + `blk_dim_x`·`thr_y` + `blk_dim_x`·`blk_dim_y`·`thr_z`. Both outputs are combinational.
- R11: A warp held by a long-outstanding write (hundreds of cycles) does not delay grants to other eligible warps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| warp_valid | input | NUM_WARPS | Warp w has a next instruction ready to be considered |
| warp_src_a | input | NUM_WARPS*RID_W | First source register per warp, warp w at bits [w*RID_W +: RID_W] |
| warp_src_b | input | NUM_WARPS*RID_W | Second source register per warp, same packing |
| warp_dst | input | NUM_WARPS*RID_W | Destination register per warp, same packing |
| wb_valid | input | 1 | Writeback completion strobe |
| wb_warp | input | WID_W | Warp of the completed write |
| wb_reg | input | RID_W | Register of the completed write |
| issue_valid | output | 1 | One-cycle grant pulse |
| issue_warp | output | WID_W | Granted warp index |
| thr_x | input | DIM_W | Thread x coordinate |
| thr_y | input | DIM_W | Thread y coordinate |
| thr_z | input | DIM_W | Thread z coordinate |
| blk_dim_x | input | DIM_W | Block extent in x |
| blk_dim_y | input | DIM_W | Block extent in y |
| thr_warp | output | 3*DIM_W-5 | Warp index of the thread |
| thr_lane | output | 5 | Lane of the thread within its warp |

## Verification
The bench collides a grant and a writeback on the same warp and register. A scheduler that let the clear win would grant that warp again with its operand still in flight. It also blocks a warp through each of its three register fields in turn, so a check that skipped the destination or one source would issue early. Further tests cover the rotation wrapping past the top warp and a single warp stalled for two hundred cycles while others issue. The first grant after a mid-run reset must go to warp 0, which exposes a pointer that reset failed to clear or that drifted while idle.

// File: rtl/warp_sched_pkg.sv
`timescale 1ns/1ps
package warp_sched_pkg;
  // Threads per warp; must be a power of two (lane = low bits of linear id).
  localparam int unsigned LANES_PER_WARP = 32;
  localparam int unsigned LANE_W         = $clog2(LANES_PER_WARP);
  localparam int unsigned DEF_WARPS      = 32;
  localparam int unsigned DEF_REGS       = 16;
  localparam int unsigned DEF_ISSUE_CYC  = 4;
  localparam int unsigned DEF_DIM_W      = 10;
endpackage

// File: rtl/warp_scoreboard.sv
`timescale 1ns/1ps
module warp_scoreboard #(
  parameter int unsigned NUM_WARPS = 32,
  parameter int unsigned NUM_REGS  = 16,
  localparam int unsigned WID_W = $clog2(NUM_WARPS),
  localparam int unsigned RID_W = $clog2(NUM_REGS),
  localparam int unsigned BITS  = NUM_WARPS * NUM_REGS,
  localparam int unsigned IDX_W = $clog2(BITS)
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic [NUM_WARPS-1:0]       valid,
  input  logic [NUM_WARPS*RID_W-1:0] src_a,
  input  logic [NUM_WARPS*RID_W-1:0] src_b,
  input  logic [NUM_WARPS*RID_W-1:0] dst,
  input  logic                       set_en,
  input  logic [WID_W-1:0]           set_warp,
  input  logic [RID_W-1:0]           set_reg,
  input  logic                       clr_en,
  input  logic [WID_W-1:0]           clr_warp,
  input  logic [RID_W-1:0]           clr_reg,
  output logic [NUM_WARPS-1:0]       elig
);
  logic [BITS-1:0]  pend_q, pend_d;
  logic [IDX_W-1:0] set_idx, clr_idx;

  assign set_idx = IDX_W'(int'(set_warp) * NUM_REGS + int'(set_reg));
  assign clr_idx = IDX_W'(int'(clr_warp) * NUM_REGS + int'(clr_reg));

  // Clear first, then set: a same-edge mark wins over a completion.
  always_comb begin
    pend_d = pend_q;
    if (clr_en) pend_d[clr_idx] = 1'b0;
    if (set_en) pend_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= '0;
    else if (set_en || clr_en)  pend_q <= pend_d;
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [NUM_REGS-1:0] row;
    logic [RID_W-1:0]    ra, rb, rd;
    assign row = pend_q[w*NUM_REGS +: NUM_REGS];
    assign ra  = src_a[w*RID_W +: RID_W];
    assign rb  = src_b[w*RID_W +: RID_W];
    assign rd  = dst[w*RID_W +: RID_W];
    assign elig[w] = valid[w] & ~row[ra] & ~row[rb] & ~row[rd];
  end

  a_r3_mark_on_grant: assert property (@(posedge clk) disable iff (!rst_ni)
    set_en |=> pend_q[$past(set_idx)]);

  a_r4_clear_on_wb: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !pend_q[$past(clr_idx)]);

  a_r5_mark_beats_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_en && set_en && set_idx == clr_idx) |=> pend_q[$past(clr_idx)]);
endmodule

// File: rtl/warp_rr_pick.sv
`timescale 1ns/1ps
module warp_rr_pick #(
  parameter int unsigned N = 32,
  localparam int unsigned W  = $clog2(N),
  localparam int unsigned W1 = W + 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  output logic         gnt_any,
  output logic [W-1:0] gnt_idx
);
  logic [W1-1:0] cand;

  // Walk offsets downward so the smallest offset from start is kept.
  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    cand    = '0;
    for (int k = N - 1; k >= 0; k--) begin
      cand = {1'b0, start} + W1'(k);
      if (cand >= W1'(N)) cand = cand - W1'(N);
      if (req[cand[W-1:0]]) begin
        gnt_any = 1'b1;
        gnt_idx = cand[W-1:0];
      end
    end
  end

  always_comb begin
    if (gnt_any) a_r6_grant_requested: assert (req[gnt_idx]);
  end
endmodule

// File: rtl/warp_thread_map.sv
`timescale 1ns/1ps
module warp_thread_map
  import warp_sched_pkg::*;
#(
  parameter int unsigned DIM_W = 10,
  localparam int unsigned LIN_W = 3 * DIM_W
) (
  input  logic [DIM_W-1:0]        tx,
  input  logic [DIM_W-1:0]        ty,
  input  logic [DIM_W-1:0]        tz,
  input  logic [DIM_W-1:0]        dx,
  input  logic [DIM_W-1:0]        dy,
  output logic [LIN_W-LANE_W-1:0] warp,
  output logic [LANE_W-1:0]       lane
);
  logic [LIN_W-1:0] lin;

  assign lin  = LIN_W'(tx)
              + LIN_W'(dx) * LIN_W'(ty)
              + LIN_W'(dx) * LIN_W'(dy) * LIN_W'(tz);
  assign warp = lin[LIN_W-1:LANE_W];
  assign lane = lin[LANE_W-1:0];
endmodule

// File: rtl/warp_sched_top.sv
`timescale 1ns/1ps
module warp_sched_top
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS    = DEF_WARPS,
  parameter int unsigned NUM_REGS     = DEF_REGS,
  parameter int unsigned ISSUE_CYCLES = DEF_ISSUE_CYC,
  parameter int unsigned DIM_W        = DEF_DIM_W,
  localparam int unsigned WID_W = $clog2(NUM_WARPS),
  localparam int unsigned RID_W = $clog2(NUM_REGS),
  localparam int unsigned CNT_W = $clog2(ISSUE_CYCLES + 1),
  localparam int unsigned TW_W  = 3 * DIM_W - LANE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_WARPS-1:0]       warp_valid,
  input  logic [NUM_WARPS*RID_W-1:0] warp_src_a,
  input  logic [NUM_WARPS*RID_W-1:0] warp_src_b,
  input  logic [NUM_WARPS*RID_W-1:0] warp_dst,
  input  logic                       wb_valid,
  input  logic [WID_W-1:0]           wb_warp,
  input  logic [RID_W-1:0]           wb_reg,
  output logic                       issue_valid,
  output logic [WID_W-1:0]           issue_warp,
  input  logic [DIM_W-1:0]           thr_x,
  input  logic [DIM_W-1:0]           thr_y,
  input  logic [DIM_W-1:0]           thr_z,
  input  logic [DIM_W-1:0]           blk_dim_x,
  input  logic [DIM_W-1:0]           blk_dim_y,
  output logic [TW_W-1:0]            thr_warp,
  output logic [LANE_W-1:0]          thr_lane
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [NUM_WARPS-1:0] elig;
  logic                 gnt_any, fire, slot_open;
  logic [WID_W-1:0]     gnt_idx, ptr_q, ptr_d;
  logic [CNT_W-1:0]     busy_q, busy_d;
  logic                 iss_v_q;
  logic [WID_W-1:0]     iss_w_q;
  logic [RID_W-1:0]     gnt_dst;

  assign gnt_dst = warp_dst[int'(gnt_idx) * RID_W +: RID_W];

  warp_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_sb (
    .clk      (clk),
    .rst_ni   (rst_i),
    .valid    (warp_valid),
    .src_a    (warp_src_a),
    .src_b    (warp_src_b),
    .dst      (warp_dst),
    .set_en   (fire),
    .set_warp (gnt_idx),
    .set_reg  (gnt_dst),
    .clr_en   (wb_valid),
    .clr_warp (wb_warp),
    .clr_reg  (wb_reg),
    .elig     (elig)
  );

  warp_rr_pick #(.N(NUM_WARPS)) u_pick (
    .req     (elig),
    .start   (ptr_q),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  warp_thread_map #(.DIM_W(DIM_W)) u_map (
    .tx   (thr_x),
    .ty   (thr_y),
    .tz   (thr_z),
    .dx   (blk_dim_x),
    .dy   (blk_dim_y),
    .warp (thr_warp),
    .lane (thr_lane)
  );

  // Next-state logic
  always_comb begin
    slot_open = (busy_q == '0);
    fire      = slot_open & gnt_any;
    ptr_d     = (gnt_idx == WID_W'(NUM_WARPS - 1)) ? '0 : gnt_idx + 1'b1;
    if (fire)               busy_d = CNT_W'(ISSUE_CYCLES - 1);
    else if (!slot_open)    busy_d = busy_q - 1'b1;
    else                    busy_d = busy_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ptr_q   <= '0;
      busy_q  <= '0;
      iss_v_q <= 1'b0;
      iss_w_q <= '0;
    end else begin
      iss_v_q <= fire;
      busy_q  <= busy_d;
      if (fire) begin
        ptr_q   <= ptr_d;
        iss_w_q <= gnt_idx;
      end
    end
  end

  assign issue_valid = iss_v_q;
  assign issue_warp  = iss_w_q;

  // Checker state: edges since last grant pulse, and last cycle's valids.
  logic [CNT_W:0]       gap_q;
  logic [NUM_WARPS-1:0] valid_d_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      gap_q     <= (CNT_W+1)'(ISSUE_CYCLES);
      valid_d_q <= '0;
    end else begin
      valid_d_q <= warp_valid;
      if (iss_v_q)                               gap_q <= (CNT_W+1)'(1);
      else if (gap_q < (CNT_W+1)'(ISSUE_CYCLES)) gap_q <= gap_q + 1'b1;
    end
  end

  a_r8_grant_spacing: assert property (@(posedge clk) disable iff (!rst_i)
    iss_v_q |-> gap_q >= (CNT_W+1)'(ISSUE_CYCLES));

  a_r2_grant_was_valid: assert property (@(posedge clk) disable iff (!rst_i)
    iss_v_q |-> valid_d_q[iss_w_q]);

  a_r7_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    (slot_open && !gnt_any) |=> !iss_v_q);

  a_r7_idle_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_i)
    (slot_open && !gnt_any) |=> $stable(ptr_q));

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_i)
    iss_v_q |=> !iss_v_q);
endmodule

// File: tb/warp_sched_top_bench.sv
`timescale 1ns/1ps
module warp_sched_top_bench;
  localparam int NW = 32;
  localparam int RW = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NW-1:0]     warp_valid;
  logic [NW*RW-1:0]  src_a_f, src_b_f, dst_f;
  logic              wb_valid;
  logic [4:0]        wb_warp;
  logic [RW-1:0]     wb_reg;
  logic              issue_valid;
  logic [4:0]        issue_warp;
  logic [9:0]        thr_x, thr_y, thr_z, blk_dim_x, blk_dim_y;
  logic [24:0]       thr_warp;
  logic [4:0]        thr_lane;

  logic [RW-1:0] ia [NW];
  logic [RW-1:0] ib [NW];
  logic [RW-1:0] id [NW];

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      src_a_f[w*RW +: RW] = ia[w];
      src_b_f[w*RW +: RW] = ib[w];
      dst_f[w*RW +: RW]   = id[w];
    end
  end

  always #2.5 clk = ~clk;

  warp_sched_top u_warp_sched_top (
    .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid),
    .warp_src_a(src_a_f), .warp_src_b(src_b_f), .warp_dst(dst_f),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .issue_valid(issue_valid), .issue_warp(issue_warp),
    .thr_x(thr_x), .thr_y(thr_y), .thr_z(thr_z),
    .blk_dim_x(blk_dim_x), .blk_dim_y(blk_dim_y),
    .thr_warp(thr_warp), .thr_lane(thr_lane)
  );

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  // Thread-to-warp vectors (R10): dims, coordinates, expected warp and lane.
  localparam int NV = 6;
  localparam int V_DX [NV] = '{8, 8, 16, 4, 32, 1};
  localparam int V_DY [NV] = '{4, 4, 16, 8, 1, 1};
  localparam int V_TX [NV] = '{3, 0, 15, 1, 31, 0};
  localparam int V_TY [NV] = '{2, 0, 15, 7, 0, 0};
  localparam int V_TZ [NV] = '{0, 1, 0, 3, 5, 64};
  localparam int V_W  [NV] = '{0, 1, 7, 3, 5, 2};
  localparam int V_L  [NV] = '{19, 0, 31, 29, 31, 0};

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_issue(input int w, input string req);
    tick();
    chk(req, "issue_valid", issue_valid, 1);
    chk(req, "issue_warp", issue_warp, w);
  endtask

  task automatic expect_idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(req, "issue_valid idle", issue_valid, 0);
    end
  endtask

  task automatic wb_pulse(input int w, input int r, input string req);
    wb_valid = 1'b1; wb_warp = 5'(w); wb_reg = RW'(r);
    tick();
    chk(req, "no grant at writeback edge", issue_valid, 0);
    wb_valid = 1'b0;
  endtask

  task automatic all_default();
    for (int w = 0; w < NW; w++) begin
      ia[w] = 4'd1; ib[w] = 4'd2; id[w] = 4'd3;
    end
    warp_valid = '1;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wb_valid = 1'b0; wb_warp = '0; wb_reg = '0;
    thr_x = '0; thr_y = '0; thr_z = '0; blk_dim_x = '0; blk_dim_y = '0;
    all_default();
    repeat (3) tick();
    chk("R1", "issue_valid in reset", issue_valid, 0);

    // R10 vector table
    for (int v = 0; v < NV; v++) begin
      blk_dim_x = 10'(V_DX[v]); blk_dim_y = 10'(V_DY[v]);
      thr_x = 10'(V_TX[v]); thr_y = 10'(V_TY[v]); thr_z = 10'(V_TZ[v]);
      #1;
      chk("R10", "thr_warp", thr_warp, V_W[v]);
      chk("R10", "thr_lane", thr_lane, V_L[v]);
    end

    // R1/R6/R8/R3: release reset, every warp issues once in order.
    rst_n = 1'b1;
    expect_idle(2, "R1");
    expect_issue(0, "R1");
    for (int k = 1; k < NW; k++) begin
      expect_idle(3, "R8");
      expect_issue(k, "R6");
    end
    // R3/R7: every warp now blocked by its own destination.
    expect_idle(8, "R7");

    // R4: clearing warp 5 lets it go on the next edge.
    wb_pulse(5, 3, "R4");
    expect_issue(5, "R4");

    // R6 wrap: warps 2 and 9 eligible, start is 6 -> 9 then 2.
    wb_pulse(2, 3, "R6");
    wb_pulse(9, 3, "R6");
    expect_idle(1, "R8");
    expect_issue(9, "R6");
    expect_idle(3, "R8");
    // R5: writeback to warp 2 reg 3 on the very edge warp 2 is granted.
    wb_valid = 1'b1; wb_warp = 5'd2; wb_reg = 4'd3;
    expect_issue(2, "R6");
    wb_valid = 1'b0;
    expect_idle(8, "R5");
    wb_pulse(2, 3, "R5");
    expect_issue(2, "R5");

    // R2: warp 7 blocked via each field.
    ia[7] = 4'd3; ib[7] = 4'd5; id[7] = 4'd6;
    expect_idle(8, "R2");
    ia[7] = 4'd5; ib[7] = 4'd3;
    expect_idle(4, "R2");
    ia[7] = 4'd5; ib[7] = 4'd6; id[7] = 4'd8;
    expect_issue(7, "R2");

    // R11: warp 7 waits on reg 8 while warps 10 and 11 issue.
    ia[7] = 4'd8; ib[7] = 4'd5; id[7] = 4'd9;
    ia[10] = 4'd12; ib[10] = 4'd13; id[10] = 4'd14;
    ia[11] = 4'd12; ib[11] = 4'd13; id[11] = 4'd14;
    expect_idle(3, "R8");
    expect_issue(10, "R11");
    expect_idle(3, "R8");
    expect_issue(11, "R11");
    expect_idle(200, "R11");
    wb_pulse(7, 8, "R11");
    expect_issue(7, "R11");

    // R2 valid flag: warp 20 cleared but not valid.
    warp_valid[20] = 1'b0;
    wb_pulse(20, 3, "R2");
    expect_idle(8, "R2");
    warp_valid[20] = 1'b1;
    expect_issue(20, "R2");

    // R1 mid-run reset: scoreboard and start pointer restored.
    all_default();
    tick();
    rst_n = 1'b0;
    #1;
    chk("R1", "issue_valid async reset", issue_valid, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    expect_idle(2, "R1");
    expect_issue(0, "R1");
    expect_idle(3, "R9");
    expect_issue(1, "R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule